// File: doc/BRIEF.md
# Streaming packet receive sink

This block sits at the user end of a receive packet stream. It drives a ready output, which has one cycle of latency, and takes beats that valid qualifies. Start-of-packet and end-of-packet markers frame each packet. At packet start it latches a beat-count value presented with the first beat, and it compares that value with the number of beats it actually accepts. It also turns the empty field of the final beat into a byte count. The empty field is counted in 16-bit steps.

For every packet it reports a byte length, valid for one cycle. Single-cycle pulses flag handshake and framing violations. The bus width is a parameter of 32 or 64 bits, and the empty field width follows from it. The payload itself, header meaning, padding and CRC are left to downstream logic.

Control is a two-state machine. `S_IDLE` means no packet is open. `S_OPEN` means a packet has started and has not yet ended.

The transitions are:
- Idle-to-open: an accepted start beat without end.
- Open-to-idle: an accepted end beat.
- Idle self-loop: a single-beat packet, an orphan beat, or no accepted beat.
- Open self-loop: a middle beat, or a restart by a new start beat.

Top module: `rx_pkt_sink`

## Requirements
- R1: `rdy` equals `take_en` in the same cycle. A beat is accepted only on a cycle that directly follows a cycle with `rdy` high.
- R2: A beat with `in_valid` high on a cycle not preceded by `rdy` high sets `err_hs` for one cycle on the next cycle. The beat is not counted and does not change the framing state.
- R3: An accepted beat with `in_sop` high opens a packet and latches `in_size`. If `in_eop` is also high, it is a complete one-beat packet.
- R4: An accepted beat without `in_sop` while no packet is open sets `err_orphan` on the next cycle. The beat is otherwise ignored, and no length is reported.
- R5: An accepted start beat while a packet is open sets `err_sop_open` on the next cycle. The open packet is dropped, and a new packet starts with the new size.
- R6: On the cycle after an accepted end beat, `len_valid` is high for one cycle. `len_bytes` then equals beats × bus bytes − empty bytes.
- R7: Empty bytes equal the empty field with its LSB forced to 0. On a 32-bit bus, 1x gives 2 bytes. On a 64-bit bus, 01x, 10x and 11x give 2, 4 and 6 bytes.
- R8: The empty field on non-final beats has no effect: such beats count the full bus width.
- R9: When the accepted beat count of a packet differs from its latched size, `err_count` is high together with `len_valid`.
- R10: `in_size` on beats without `in_sop` has no effect on the count check.
- R11: After reset the block is idle and all result and error outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_en | input | 1 | Local request to receive on the next cycle |
| rdy | output | 1 | Ready to the stream source |
| in_valid | input | 1 | Beat qualifier |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_empty | input | EW | Unused bytes on the last beat (LSB ignored) |
| in_size | input | SW | Packet length in beats, read on the start beat |
| len_valid | output | 1 | Packet length strobe |
| len_bytes | output | SW+1+EW | Packet length in bytes |
| err_hs | output | 1 | Beat offered on a non-ready cycle |
| err_orphan | output | 1 | Beat outside any packet |
| err_sop_open | output | 1 | Start beat while a packet is open |
| err_count | output | 1 | Beat count differs from latched size |

## Verification
Directed packets cover several cases:
- one-beat packets;
- multi-beat packets with each empty code, including codes with the LSB set, which separate a correct halfword decode from a raw byte count;
- middle beats carrying a non-zero empty field and changing size values, which show whether either leaks outside the beat where it belongs.

Random streams mix gaps in ready and valid with stray start and end markers, and a requirement-based model predicts each output. Those streams tell the four violation kinds apart: restarts, orphans, non-ready beats and count mismatches.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic {
        S_IDLE = 1'b0,
        S_OPEN = 1'b1
    } rs_state_e;
endpackage

// File: rtl/rs_ready_track.sv
module rs_ready_track (
    input  logic clk,
    input  logic rst_n,
    input  logic take_en,
    output logic rdy,
    output logic rdy_d
);
    assign rdy = take_en;

    always_ff @(posedge clk) begin
        if (!rst_n) rdy_d <= 1'b0;
        else        rdy_d <= rdy;
    end
endmodule

// File: rtl/rs_empty_decode.sv
module rs_empty_decode #(
    parameter int EW = 3
) (
    input  logic [EW-1:0] field,
    input  logic          last,
    output logic [EW-1:0] bytes
);
    localparam logic [EW-1:0] HALF_MASK = {{(EW-1){1'b1}}, 1'b0};

    always_comb begin
        bytes = last ? (field & HALF_MASK) : '0;
    end

    // R7
    empty_even_chk: assert final (bytes[0] == 1'b0);
endmodule

// File: rtl/rs_frame_fsm.sv
module rs_frame_fsm
    import rs_pkg::*;
#(
    parameter int SW = 8,
    parameter int EW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc,
    input  logic                 sop,
    input  logic                 eop,
    input  logic [EW-1:0]        empty_bytes,
    input  logic [SW-1:0]        size,
    output logic                 len_valid,
    output logic [SW+EW:0]       len_bytes,
    output logic                 err_orphan,
    output logic                 err_sop_open,
    output logic                 err_count
);
    localparam int CW = SW + 1;
    localparam int LW = CW + EW;

    rs_state_e       state, nstate;
    logic [CW-1:0]   cnt;
    logic [SW-1:0]   sz;
    logic [CW-1:0]   cnt_inc;
    logic [CW-1:0]   beats_now;
    logic [SW-1:0]   sz_now;

    always_comb begin
        cnt_inc   = (cnt == {CW{1'b1}}) ? cnt : cnt + CW'(1);
        beats_now = sop ? CW'(1) : cnt_inc;
        sz_now    = sop ? size : sz;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE: if (acc && sop && !eop) nstate = S_OPEN;
            S_OPEN: if (acc && eop)         nstate = S_IDLE;
            default:                        nstate = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sz  <= '0;
        end else if (acc && sop) begin
            cnt <= CW'(1);
            sz  <= size;
        end else if (acc && state == S_OPEN) begin
            cnt <= beats_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_valid    <= 1'b0;
            len_bytes    <= '0;
            err_orphan   <= 1'b0;
            err_sop_open <= 1'b0;
            err_count    <= 1'b0;
        end else begin
            len_valid    <= 1'b0;
            len_bytes    <= '0;
            err_orphan   <= 1'b0;
            err_sop_open <= 1'b0;
            err_count    <= 1'b0;
            if (acc) begin
                unique case (state)
                    S_IDLE: if (!sop) err_orphan <= 1'b1;
                    S_OPEN: if (sop)  err_sop_open <= 1'b1;
                    default: ;
                endcase
                if (eop && (sop || state == S_OPEN)) begin
                    len_valid <= 1'b1;
                    len_bytes <= {beats_now, {EW{1'b0}}} - LW'(empty_bytes);
                    err_count <= (beats_now != {1'b0, sz_now});
                end
            end
        end
    end

    // R4
    orphan_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && acc && !sop) |=> err_orphan);
    // R6
    len_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_valid |-> $past(acc && eop));
    // R5
    restart_when_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_sop_open |-> $past(state == S_OPEN));
    // R4
    orphan_no_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_orphan |-> !len_valid);
endmodule

// File: rtl/rx_pkt_sink.sv
module rx_pkt_sink #(
    parameter int DW = 64,
    parameter int SW = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          take_en,
    output logic                          rdy,
    input  logic                          in_valid,
    input  logic                          in_sop,
    input  logic                          in_eop,
    input  logic [$clog2(DW/8)-1:0]       in_empty,
    input  logic [SW-1:0]                 in_size,
    output logic                          len_valid,
    output logic [SW+$clog2(DW/8):0]      len_bytes,
    output logic                          err_hs,
    output logic                          err_orphan,
    output logic                          err_sop_open,
    output logic                          err_count
);
    localparam int BYTES = DW / 8;
    localparam int EW    = $clog2(BYTES);

    logic          rdy_d;
    logic          acc;
    logic [EW-1:0] empty_bytes;

    generate
        if (DW != 32 && DW != 64) begin : g_bad_width
            initial $error("rx_pkt_sink: DW must be 32 or 64");
        end
    endgenerate

    rs_ready_track u_rdy (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_en (take_en),
        .rdy     (rdy),
        .rdy_d   (rdy_d)
    );

    assign acc = in_valid & rdy_d;

    rs_empty_decode #(.EW(EW)) u_empty (
        .field (in_empty),
        .last  (in_eop),
        .bytes (empty_bytes)
    );

    rs_frame_fsm #(.SW(SW), .EW(EW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc          (acc),
        .sop          (in_sop),
        .eop          (in_eop),
        .empty_bytes  (empty_bytes),
        .size         (in_size),
        .len_valid    (len_valid),
        .len_bytes    (len_bytes),
        .err_orphan   (err_orphan),
        .err_sop_open (err_sop_open),
        .err_count    (err_count)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) err_hs <= 1'b0;
        else        err_hs <= in_valid & ~rdy_d;
    end

    // R2
    hs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy ##1 in_valid) |=> err_hs);
    // R2
    hs_no_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy ##1 (in_valid && in_eop)) |=> !len_valid);
    // R9
    count_with_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_count |-> len_valid);
endmodule

// File: tb/rx_pkt_sink_test.sv
module rx_pkt_sink_test;
    localparam int DW = 64;
    localparam int SW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        take_en = 1'b0;
    logic        rdy;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [2:0]  in_empty = '0;
    logic [7:0]  in_size = '0;
    logic        len_valid;
    logic [11:0] len_bytes;
    logic        err_hs, err_orphan, err_sop_open, err_count;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state
    bit         m_open = 0;
    int         m_cnt = 0;
    int         m_sz = 0;
    bit         m_rdyd = 0;

    always #5 clk = ~clk;

    rx_pkt_sink #(.DW(DW), .SW(SW)) uut (
        .clk(clk), .rst_n(rst_n), .take_en(take_en), .rdy(rdy),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_empty(in_empty), .in_size(in_size),
        .len_valid(len_valid), .len_bytes(len_bytes),
        .err_hs(err_hs), .err_orphan(err_orphan),
        .err_sop_open(err_sop_open), .err_count(err_count)
    );

    task automatic chk(input string rq, input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s): actual=%0d expected=%0d", rq, tag, act, exp);
        end
    endtask

    function automatic int empty_to_bytes(input logic [2:0] f);
        return int'(f & 3'b110);
    endfunction

    task automatic step(input bit te, input bit v, input bit s, input bit e,
                        input logic [2:0] emp, input int sz, input string tag);
        bit e_lv = 0, e_hs = 0, e_or = 0, e_so = 0, e_ce = 0;
        int e_len = 0;
        int beats = 0;
        int szn = 0;
        take_en = te; in_valid = v; in_sop = s; in_eop = e;
        in_empty = emp; in_size = 8'(sz);
        #1;
        chk("R1", tag, int'(rdy), int'(te));
        if (v && !m_rdyd) e_hs = 1;
        if (v && m_rdyd) begin
            if (s) begin
                if (m_open) e_so = 1;
                if (e) begin
                    beats = 1; szn = sz; m_open = 0;
                end else begin
                    m_open = 1; m_cnt = 1; m_sz = sz;
                end
            end else if (!m_open) begin
                e_or = 1;
            end else begin
                m_cnt++;
                if (e) begin
                    beats = m_cnt; szn = m_sz; m_open = 0;
                end
            end
            if (beats != 0) begin
                e_lv = 1;
                e_len = beats * (DW / 8) - empty_to_bytes(emp);
                e_ce = (beats != szn);
            end
        end
        m_rdyd = te;
        @(posedge clk);
        @(negedge clk);
        chk("R6", tag, int'(len_valid), int'(e_lv));
        if (e_lv) chk("R6", tag, int'(len_bytes), e_len);
        chk("R2", tag, int'(err_hs), int'(e_hs));
        chk("R4", tag, int'(err_orphan), int'(e_or));
        chk("R5", tag, int'(err_sop_open), int'(e_so));
        chk("R9", tag, int'(err_count), int'(e_ce));
    endtask

    initial begin : watchdog
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R11: reset state
        chk("R11", "reset", int'(len_valid), 0);
        chk("R11", "reset", int'(err_hs | err_orphan | err_sop_open | err_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "after reset", int'(len_valid | err_hs), 0);

        // R3: one-beat packet
        step(1, 0, 0, 0, 3'b000, 0, "prime");
        step(1, 1, 1, 1, 3'b000, 1, "R3 single");
        // R7: empty codes, with LSB set
        step(1, 1, 1, 0, 3'b000, 3, "R7 open");
        step(1, 1, 0, 0, 3'b000, 0, "R7 mid");
        step(1, 1, 0, 1, 3'b111, 0, "R7 code 11x");
        step(1, 1, 1, 1, 3'b011, 1, "R7 code 01x");
        step(1, 1, 1, 1, 3'b101, 1, "R7 code 10x");
        step(1, 1, 1, 1, 3'b001, 1, "R7 code 00x");
        // R8 and R10: middle beats carry empty and size junk
        step(1, 1, 1, 0, 3'b000, 3, "R10 open");
        step(1, 1, 0, 0, 3'b110, 9, "R8 mid empty");
        step(1, 1, 0, 1, 3'b000, 7, "R10 end");
        // R9: mismatch
        step(1, 1, 1, 0, 3'b000, 4, "R9 open");
        step(1, 1, 0, 1, 3'b010, 0, "R9 short");
        // R4: orphan beats
        step(1, 1, 0, 0, 3'b000, 0, "R4 orphan");
        step(1, 1, 0, 1, 3'b100, 0, "R4 orphan eop");
        // R5: restart
        step(1, 1, 1, 0, 3'b000, 5, "R5 first");
        step(1, 1, 1, 0, 3'b000, 2, "R5 restart");
        step(1, 1, 0, 1, 3'b000, 0, "R5 end");
        // R2: non-ready beat, then R1 ready latency
        step(0, 0, 0, 0, 3'b000, 0, "R2 drop rdy");
        step(1, 1, 1, 1, 3'b000, 1, "R2 beat on non-ready");
        step(1, 1, 1, 1, 3'b000, 1, "R1 ready cycle");

        for (int i = 0; i < 1500; i++) begin
            bit te = ($urandom_range(0, 9) < 8);
            bit v  = ($urandom_range(0, 9) < 7);
            bit s  = ($urandom_range(0, 3) == 0);
            bit e  = ($urandom_range(0, 9) < 3);
            logic [2:0] em = 3'($urandom_range(0, 7));
            int sz = $urandom_range(1, 4);
            step(te, v, s, e, em, sz, "random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule